// File: doc/BRIEF.md
# Potentiometer Command Sequencer

This block sits behind a two-wire serial slave front end and interprets everything that arrives after the address byte of a frame. The first byte it receives carries an opcode, a data-register index and a pot index. It then keeps two kinds of storage for four digitally set potentiometers. The first is the wiper position of each pot, which is volatile and drives the tap decoder. The second is a bank of sixteen 6-bit data registers, four per pot, modelled here as flops in place of nonvolatile cells. From the opcode the block reads or writes either kind of storage. It also copies values between them, for one pot or for all four at once, and can step a wiper up and down one tap at a time.

Every change to a data register is treated as a nonvolatile write. It is held back until the frame ends with a stop, and then only if the write-protect input is high. The stop then starts a busy window with a length set by a parameter in clock cycles. While that window lasts, the block accepts no frame activity at all, and the front end uses the busy flag to withhold its address acknowledge. For read commands the block presents the reply byte together with a one-cycle strobe, and the front end shifts that byte out.

Top module: `pot_cmd_seq`

## Requirements
- R1: The first byte after a start is the instruction: bits [7:4] are the opcode, bits [3:2] select the data register, and bits [1:0] select the pot. The opcodes are 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 copy data register to wiper, 1110 copy wiper to data register, 0001 copy data register to wiper for all pots, 1000 copy wiper to data register for all pots, and 0010 step mode.
- R2: A read-wiper or read-register instruction raises tx_vld_o for exactly one cycle, starting in the cycle after the instruction byte is accepted. In that cycle tx_byte_o is {2'b00, value}.
- R3: In a write-wiper command, the low six bits of the byte after the instruction load the selected wiper, starting in the cycle after that byte is accepted. The two upper bits are ignored.
- R4: A write-register command changes the selected data register only when a stop follows its data byte. The new value is visible from the cycle after that stop.
- R5: A single copy from data register to wiper, and the all-pot copy from register index R to each wiper, take effect in the cycle after the instruction byte.
- R6: A single copy from wiper to data register, and the all-pot copy from each wiper into that pot's register R, are committed at the following stop.
- R7: If a start arrives before the stop, any pending data-register write is discarded.
- R8: When wp_n_i is low at the stop, no data register changes and no busy window begins.
- R9: A committed data-register write holds busy_o high for exactly BUSY_CYCLES cycles, starting in the cycle after the stop. During that window, starts, bytes, stops and steps have no effect.
- R10: In step mode, each step pulse moves the selected wiper by one tap (up when step_up_i is 1, down otherwise). The wiper stops at 63 and at 0. Step pulses outside step mode are ignored.
- R11: An instruction byte with any other opcode is ignored. It changes no register and sends no reply, and further bytes in that frame are also ignored.
- R12: After reset, every wiper and data register is 0, busy_o is low and tx_vld_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start with matching address seen (one-cycle pulse) |
| stop_i | input | 1 | Stop condition seen (one-cycle pulse) |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| step_i | input | 1 | Step pulse in step mode |
| step_up_i | input | 1 | Step direction, 1 = up |
| wp_n_i | input | 1 | Write enable for data registers, low blocks |
| tx_vld_o | output | 1 | Reply byte strobe |
| tx_byte_o | output | 8 | Reply byte |
| busy_o | output | 1 | Nonvolatile write in progress |
| wiper_o | output | 24 | Four 6-bit wiper positions, pot 0 in the low bits |

## Verification
The embedded properties check several rules on every cycle. A data register may change only in the cycle after a stop that arrives with write enable high and no busy window active. The busy window freezes both the register bank and the wipers. A stop with protection on never starts a busy window. A wiper at either end stays there when stepped further, and the reply strobe lasts one cycle. The bench's reference model covers what a single property cannot express: whole command sequences such as abort by a new start, the all-pot copies, and how the instruction fields are decoded. Data registers have no output port, so their contents are read back through read-register commands.

// File: rtl/pot_pkg.sv
package pot_pkg;

    localparam int FLD_W = 2;

    localparam logic [3:0] OPC_GD2W   = 4'b0001;
    localparam logic [3:0] OPC_STEP   = 4'b0010;
    localparam logic [3:0] OPC_GW2D   = 4'b1000;
    localparam logic [3:0] OPC_RD_WIP = 4'b1001;
    localparam logic [3:0] OPC_WR_WIP = 4'b1010;
    localparam logic [3:0] OPC_RD_DR  = 4'b1011;
    localparam logic [3:0] OPC_WR_DR  = 4'b1100;
    localparam logic [3:0] OPC_D2W    = 4'b1101;
    localparam logic [3:0] OPC_W2D    = 4'b1110;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_WIP,
        CMD_WR_WIP,
        CMD_RD_DR,
        CMD_WR_DR,
        CMD_D2W,
        CMD_W2D,
        CMD_GD2W,
        CMD_GW2D,
        CMD_STEP
    } cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_INSTR,
        SQ_DATA,
        SQ_STEP,
        SQ_DONE
    } seq_e;

    typedef enum logic [1:0] {
        PND_NONE,
        PND_DR_WRITE,
        PND_W2D,
        PND_GW2D
    } pend_e;

endpackage

// File: rtl/pot_decode.sv
module pot_decode
    import pot_pkg::*;
(
    input  logic [7:0]       ins_i,
    output cmd_e             cmd_o,
    output logic [FLD_W-1:0] rsel_o,
    output logic [FLD_W-1:0] psel_o
);
    logic [3:0] opc;

    always_comb begin
        opc    = ins_i[7:4];
        rsel_o = ins_i[3:2];
        psel_o = ins_i[1:0];
        case (opc)
            OPC_RD_WIP: cmd_o = CMD_RD_WIP;
            OPC_WR_WIP: cmd_o = CMD_WR_WIP;
            OPC_RD_DR:  cmd_o = CMD_RD_DR;
            OPC_WR_DR:  cmd_o = CMD_WR_DR;
            OPC_D2W:    cmd_o = CMD_D2W;
            OPC_W2D:    cmd_o = CMD_W2D;
            OPC_GD2W:   cmd_o = CMD_GD2W;
            OPC_GW2D:   cmd_o = CMD_GW2D;
            OPC_STEP:   cmd_o = CMD_STEP;
            default:    cmd_o = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/pot_busy_timer.sv
module pot_busy_timer #(
    parameter int BUSY_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // a new window may only open once the previous one has closed
    assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

    // once the window is over, the flag stays low until the next load
    assert_stay_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> !busy_o);
endmodule

// File: rtl/pot_regfile.sv
module pot_regfile #(
    parameter int NPOT  = 4,
    parameter int NREG  = 4,
    parameter int VAL_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPOT-1:0]             wip_we_i,
    input  logic [NPOT*VAL_W-1:0]       wip_wd_i,
    input  logic [NPOT-1:0]             dr_we_i,
    input  logic [$clog2(NREG)-1:0]     dr_wsel_i,
    input  logic [NPOT*VAL_W-1:0]       dr_wd_i,
    output logic [NPOT*VAL_W-1:0]       wip_o,
    output logic [NPOT*NREG*VAL_W-1:0]  dr_o
);
    localparam int RSEL_W = $clog2(NREG);

    logic [VAL_W-1:0] wip_d [NPOT];
    logic [VAL_W-1:0] wip_q [NPOT];
    logic [VAL_W-1:0] dr_d  [NPOT][NREG];
    logic [VAL_W-1:0] dr_q  [NPOT][NREG];

    always_comb begin
        for (int p = 0; p < NPOT; p++) begin
            wip_d[p] = wip_we_i[p] ? wip_wd_i[p*VAL_W +: VAL_W] : wip_q[p];
            for (int r = 0; r < NREG; r++) begin
                dr_d[p][r] = (dr_we_i[p] && (dr_wsel_i == RSEL_W'(r)))
                           ? dr_wd_i[p*VAL_W +: VAL_W] : dr_q[p][r];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPOT; p++) begin
                wip_q[p] <= '0;
                for (int r = 0; r < NREG; r++) dr_q[p][r] <= '0;
            end
        end else begin
            for (int p = 0; p < NPOT; p++) begin
                wip_q[p] <= wip_d[p];
                for (int r = 0; r < NREG; r++) dr_q[p][r] <= dr_d[p][r];
            end
        end
    end

    for (genvar gp = 0; gp < NPOT; gp++) begin : g_pot
        assign wip_o[gp*VAL_W +: VAL_W] = wip_q[gp];
        for (genvar gr = 0; gr < NREG; gr++) begin : g_reg
            assign dr_o[(gp*NREG+gr)*VAL_W +: VAL_W] = dr_q[gp][gr];
        end
    end
endmodule

// File: rtl/pot_cmd_seq.sv
module pot_cmd_seq
    import pot_pkg::*;
#(
    parameter int NPOT        = 4,
    parameter int NREG        = 4,
    parameter int VAL_W       = 6,
    parameter int BUSY_CYCLES = 1000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  byte_vld_i,
    input  logic [7:0]            byte_i,
    input  logic                  step_i,
    input  logic                  step_up_i,
    input  logic                  wp_n_i,
    output logic                  tx_vld_o,
    output logic [7:0]            tx_byte_o,
    output logic                  busy_o,
    output logic [NPOT*VAL_W-1:0] wiper_o
);
    localparam int RSEL_W = $clog2(NREG);
    localparam int PSEL_W = $clog2(NPOT);
    localparam int DR_W   = NPOT * NREG * VAL_W;
    localparam logic [VAL_W-1:0] MAXV = {VAL_W{1'b1}};

    typedef struct packed {
        seq_e              st;
        cmd_e              cmd;
        logic [PSEL_W-1:0] pot;
        logic [RSEL_W-1:0] rsel;
        pend_e             pend;
        logic [VAL_W-1:0]  pdata;
        logic              tx_vld;
        logic [7:0]        tx_byte;
    } seq_t;

    seq_t s_d, s_q;

    cmd_e                  dec_cmd;
    logic [FLD_W-1:0]      dec_rsel, dec_pot;
    logic [NPOT-1:0]       wip_we, dr_we;
    logic [NPOT*VAL_W-1:0] wip_wd, dr_wd, wip_flat;
    logic [RSEL_W-1:0]     dr_wsel;
    logic [DR_W-1:0]       dr_flat;
    logic                  busy_load;
    logic [VAL_W-1:0]      sel_wip;

    function automatic logic [VAL_W-1:0] dr_at(input logic [DR_W-1:0] f,
                                               input int p, input int r);
        return f[(p*NREG + r)*VAL_W +: VAL_W];
    endfunction

    function automatic logic [7:0] pad(input logic [VAL_W-1:0] v);
        return {{(8-VAL_W){1'b0}}, v};
    endfunction

    pot_decode u_dec (
        .ins_i  (byte_i),
        .cmd_o  (dec_cmd),
        .rsel_o (dec_rsel),
        .psel_o (dec_pot)
    );

    pot_regfile #(.NPOT(NPOT), .NREG(NREG), .VAL_W(VAL_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wip_we_i  (wip_we),
        .wip_wd_i  (wip_wd),
        .dr_we_i   (dr_we),
        .dr_wsel_i (dr_wsel),
        .dr_wd_i   (dr_wd),
        .wip_o     (wip_flat),
        .dr_o      (dr_flat)
    );

    pot_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (busy_load),
        .busy_o (busy_o)
    );

    assign sel_wip = wip_flat[s_q.pot*VAL_W +: VAL_W];

    always_comb begin
        s_d        = s_q;
        s_d.tx_vld = 1'b0;
        wip_we     = '0;
        wip_wd     = wip_flat;
        dr_we      = '0;
        dr_wsel    = s_q.rsel;
        dr_wd      = wip_flat;
        busy_load  = 1'b0;
        if (!busy_o) begin
            if (start_i) begin
                s_d.st   = SQ_INSTR;
                s_d.pend = PND_NONE;
            end else if (stop_i) begin
                if (wp_n_i && (s_q.pend != PND_NONE)) begin
                    busy_load = 1'b1;
                    case (s_q.pend)
                        PND_DR_WRITE: begin
                            dr_we[s_q.pot] = 1'b1;
                            dr_wd[s_q.pot*VAL_W +: VAL_W] = s_q.pdata;
                        end
                        PND_W2D:  dr_we[s_q.pot] = 1'b1;
                        PND_GW2D: dr_we = '1;
                        default:  ;
                    endcase
                end
                s_d.st   = SQ_IDLE;
                s_d.pend = PND_NONE;
            end else if (byte_vld_i) begin
                case (s_q.st)
                    SQ_INSTR: begin
                        s_d.cmd  = dec_cmd;
                        s_d.pot  = dec_pot;
                        s_d.rsel = dec_rsel;
                        s_d.st   = SQ_DONE;
                        case (dec_cmd)
                            CMD_RD_WIP: begin
                                s_d.tx_vld  = 1'b1;
                                s_d.tx_byte = pad(wip_flat[dec_pot*VAL_W +: VAL_W]);
                            end
                            CMD_RD_DR: begin
                                s_d.tx_vld  = 1'b1;
                                s_d.tx_byte = pad(dr_at(dr_flat, int'(dec_pot), int'(dec_rsel)));
                            end
                            CMD_WR_WIP, CMD_WR_DR: s_d.st = SQ_DATA;
                            CMD_D2W: begin
                                wip_we[dec_pot] = 1'b1;
                                wip_wd[dec_pot*VAL_W +: VAL_W] =
                                    dr_at(dr_flat, int'(dec_pot), int'(dec_rsel));
                            end
                            CMD_GD2W: begin
                                for (int p = 0; p < NPOT; p++) begin
                                    wip_we[p] = 1'b1;
                                    wip_wd[p*VAL_W +: VAL_W] = dr_at(dr_flat, p, int'(dec_rsel));
                                end
                            end
                            CMD_W2D:  s_d.pend = PND_W2D;
                            CMD_GW2D: s_d.pend = PND_GW2D;
                            CMD_STEP: s_d.st   = SQ_STEP;
                            default:  ;
                        endcase
                    end
                    SQ_DATA: begin
                        s_d.st = SQ_DONE;
                        if (s_q.cmd == CMD_WR_WIP) begin
                            wip_we[s_q.pot] = 1'b1;
                            wip_wd[s_q.pot*VAL_W +: VAL_W] = byte_i[VAL_W-1:0];
                        end else begin
                            s_d.pend  = PND_DR_WRITE;
                            s_d.pdata = byte_i[VAL_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end else if (step_i && (s_q.st == SQ_STEP)) begin
                if (step_up_i && (sel_wip != MAXV)) begin
                    wip_we[s_q.pot] = 1'b1;
                    wip_wd[s_q.pot*VAL_W +: VAL_W] = sel_wip + 1'b1;
                end else if (!step_up_i && (sel_wip != '0)) begin
                    wip_we[s_q.pot] = 1'b1;
                    wip_wd[s_q.pot*VAL_W +: VAL_W] = sel_wip - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, cmd: CMD_NONE, pend: PND_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_vld_o  = s_q.tx_vld;
    assign tx_byte_o = s_q.tx_byte;
    assign wiper_o   = wip_flat;

    // register bank moves only right after an accepted, enabled stop
    assert_dr_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dr_flat) |-> $past(stop_i && wp_n_i && !busy_o));

    // protection on at the stop: nothing stored, no window
    assert_wp_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !wp_n_i) |=> ($stable(dr_flat) && !$rose(busy_o)));

    // everything frozen while the window is open
    assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(dr_flat) && $stable(wip_flat)));

    // end stops of step mode
    assert_sat_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !stop_i && !byte_vld_i && step_i && step_up_i
         && (s_q.st == SQ_STEP) && (sel_wip == MAXV)) |=> (sel_wip == MAXV));

    assert_sat_bottom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !stop_i && !byte_vld_i && step_i && !step_up_i
         && (s_q.st == SQ_STEP) && (sel_wip == '0)) |=> (sel_wip == '0));

    // reply strobe is a single cycle
    assert_tx_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_vld_o |=> !tx_vld_o);
endmodule

// File: tb/tb_pot_cmd_seq.sv
module tb_pot_cmd_seq;
    localparam int BUSY = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, byte_vld_i = 0, step_i = 0, step_up_i = 0;
    logic wp_n_i = 1;
    logic [7:0] byte_i = 8'h00;
    logic tx_vld_o, busy_o;
    logic [7:0] tx_byte_o;
    logic [23:0] wiper_o;

    always #5 clk = ~clk;

    pot_cmd_seq #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .step_i(step_i),
        .step_up_i(step_up_i), .wp_n_i(wp_n_i), .tx_vld_o(tx_vld_o),
        .tx_byte_o(tx_byte_o), .busy_o(busy_o), .wiper_o(wiper_o)
    );

    // reference model
    int mw[4];
    int md[4][4];
    int mst;   // 0 idle, 1 instr, 2 data, 3 step, 4 done
    int mcmd, mp, mr, mpend, mpd, mbusy;
    bit etx;
    int etx_val;

    int n_cmp = 0, n_bad = 0;
    string tag = "R12";
    bit done = 0;

    task automatic cmp(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        for (int p = 0; p < 4; p++) cmp($sformatf("wiper%0d", p), int'(wiper_o[p*6 +: 6]), mw[p]);
        cmp("busy", int'(busy_o), int'(mbusy > 0));
        cmp("tx_vld", int'(tx_vld_o), int'(etx));
        if (etx) cmp("tx_byte", int'(tx_byte_o), etx_val);
    endtask

    task automatic model_step();
        etx = 0;
        if (mbusy > 0) begin
            mbusy--;
        end else if (start_i) begin
            mst = 1; mpend = 0;
        end else if (stop_i) begin
            if (mpend != 0 && wp_n_i) begin
                if (mpend == 1) md[mp][mr] = mpd;
                else if (mpend == 2) md[mp][mr] = mw[mp];
                else for (int q = 0; q < 4; q++) md[q][mr] = mw[q];
                mbusy = BUSY;
            end
            mpend = 0; mst = 0;
        end else if (byte_vld_i) begin
            if (mst == 1) begin
                int op;
                op = int'(byte_i[7:4]); mr = int'(byte_i[3:2]); mp = int'(byte_i[1:0]);
                mcmd = op; mst = 4;
                case (op)
                    9:  begin etx = 1; etx_val = mw[mp]; end
                    11: begin etx = 1; etx_val = md[mp][mr]; end
                    10, 12: mst = 2;
                    13: mw[mp] = md[mp][mr];
                    1:  for (int q = 0; q < 4; q++) mw[q] = md[q][mr];
                    14: mpend = 2;
                    8:  mpend = 3;
                    2:  mst = 3;
                    default: ;
                endcase
            end else if (mst == 2) begin
                if (mcmd == 10) mw[mp] = int'(byte_i) & 63;
                else begin mpend = 1; mpd = int'(byte_i) & 63; end
                mst = 4;
            end
        end else if (step_i && mst == 3) begin
            if (step_up_i && mw[mp] < 63) mw[mp]++;
            else if (!step_up_i && mw[mp] > 0) mw[mp]--;
        end
    endtask

    task automatic run_cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic do_start(); start_i = 1; run_cycle(); start_i = 0; endtask
    task automatic do_stop();  stop_i = 1;  run_cycle(); stop_i = 0;  endtask
    task automatic do_byte(input logic [7:0] b);
        byte_i = b; byte_vld_i = 1; run_cycle(); byte_vld_i = 0;
    endtask
    task automatic do_step(input logic up);
        step_up_i = up; step_i = 1; run_cycle(); step_i = 0;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) run_cycle();
    endtask
    task automatic cmd3(input logic [7:0] ins, input logic [7:0] d);
        do_start(); do_byte(ins); do_byte(d); do_stop();
    endtask
    task automatic cmd2(input logic [7:0] ins);
        do_start(); do_byte(ins); do_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 4; p++) begin
            mw[p] = 0;
            for (int r = 0; r < 4; r++) md[p][r] = 0;
        end
        mst = 0; mcmd = 0; mp = 0; mr = 0; mpend = 0; mpd = 0; mbusy = 0; etx = 0; etx_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R12"; check_all(); idle(2);

        // R1 R3: write each wiper, upper data bits set
        tag = "R3";
        for (int p = 0; p < 4; p++) cmd3({4'b1010, 2'b00, 2'(p)}, 8'hC0 | 8'(p*9 + 5));
        // R2: read each wiper back
        tag = "R2";
        for (int p = 0; p < 4; p++) cmd2({4'b1001, 2'b11, 2'(p)});

        // R4: data register write, then read it back after the window
        tag = "R4";
        cmd3({4'b1100, 2'd2, 2'd1}, 8'h15);
        // R9: commands during the window are ignored
        tag = "R9";
        cmd3({4'b1010, 2'd0, 2'd0}, 8'h3E);
        do_step(1'b1);
        idle(BUSY);
        tag = "R4";
        cmd2({4'b1011, 2'd2, 2'd1});

        // R8: protection blocks the store and the window
        tag = "R8";
        wp_n_i = 0;
        cmd3({4'b1100, 2'd1, 2'd3}, 8'h3F);
        wp_n_i = 1;
        idle(3);
        cmd2({4'b1011, 2'd1, 2'd3});

        // R7: restart before stop discards pending write
        tag = "R7";
        do_start(); do_byte({4'b1100, 2'd3, 2'd0}); do_byte(8'h11);
        do_start(); do_stop();
        idle(3);
        cmd2({4'b1011, 2'd3, 2'd0});

        // R5: single copy register -> wiper, then all-pot copy
        tag = "R5";
        cmd2({4'b1101, 2'd2, 2'd1});
        for (int p = 0; p < 4; p++) begin
            cmd3({4'b1100, 2'd1, 2'(p)}, 8'(40 + p));
            idle(BUSY + 1);
        end
        cmd2({4'b0001, 2'd1, 2'd0});

        // R6: single and all-pot copy wiper -> register
        tag = "R6";
        cmd3({4'b1010, 2'd0, 2'd2}, 8'h07);
        cmd2({4'b1110, 2'd3, 2'd2});
        idle(BUSY + 1);
        cmd2({4'b1011, 2'd3, 2'd2});
        for (int p = 0; p < 4; p++) cmd3({4'b1010, 2'd0, 2'(p)}, 8'(20 + p));
        cmd2({4'b1000, 2'd0, 2'd0});
        idle(BUSY + 1);
        for (int p = 0; p < 4; p++) cmd2({4'b1011, 2'd0, 2'(p)});

        // R10: stepping with saturation at both ends
        tag = "R10";
        cmd3({4'b1010, 2'd0, 2'd3}, 8'd61);
        do_start(); do_byte({4'b0010, 2'd0, 2'd3});
        for (int i = 0; i < 4; i++) do_step(1'b1);
        for (int i = 0; i < 66; i++) do_step(1'b0);
        do_step(1'b1);
        do_stop();
        do_step(1'b1); do_step(1'b0);
        idle(2);

        // R11: unknown opcodes
        tag = "R11";
        do_start(); do_byte(8'h3F); do_byte(8'h55); do_stop();
        cmd2(8'h05);
        cmd2(8'hF2);
        do_start(); do_byte(8'h70); do_byte(8'h9A); do_stop();
        idle(3);

        // R1: pot/register fields route to distinct locations
        tag = "R1";
        for (int p = 0; p < 4; p++) cmd2({4'b1011, 2'd1, 2'(p)});
        cmd2({4'b1011, 2'd2, 2'd1});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule